// File: doc/BRIEF.md
# SPI Burst Master with Length-Controlled Chip Select

This block is an SPI master that sends one burst of a programmed number of bits. A 12-bit length input gives the burst size as the field value plus one, so a burst holds 1 to 4096 bits. Outgoing data arrives as 32-bit words on a valid/ready stream into a small transmit FIFO. Incoming data leaves as 32-bit words on a valid/ready stream from a small receive FIFO.

The burst is split into words. The first word carries only the remainder bits, taken from the low end of the first transmit entry. Every later word is a full 32 bits. The select mode decides what chip select does between words. In single mode, select stays active across all words. In per-word mode, select is released between words for a programmed gap. In either mode, the burst stops early if the transmit FIFO is empty when the next word is due.

A start-mode input decides when a burst begins. In automatic mode it begins as soon as transmit data is present. In manual mode it waits for a start pulse.

Stream rules: a transmit word is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the transmit FIFO is full. A receive word is handed over on an edge where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value. Receive back-pressure never stalls the shifter: a word that finds the receive FIFO full is lost.

Top module: `spi_burst_master`

## Requirements
- R1: A burst shifts exactly `cfg_len`+1 bits on MOSI, most significant bit first. The first word uses the low (`cfg_len` mod 32)+1 bits of the first transmit entry. Each later word uses all 32 bits of the next entry.
- R2: With `cfg_single`=1, chip select goes active once and stays active until the last bit of the burst has been shifted.
- R3: With `cfg_single`=0, chip select goes inactive after every word and becomes active again for the next word of the same burst.
- R4: Each gap where select is inactive, whether between words or after a burst, lasts `cfg_gap`·2·max(`cfg_half`,1)+1 clock cycles. No SCLK edges occur during the gap.
- R5: If the transmit FIFO is empty when the next word of a burst is due, the burst ends and select goes inactive. `underflow` then goes high and stays high until the next burst starts, and no `done` pulse is given.
- R6: Each word produces exactly one receive entry, written after its last bit has been sampled. The entry holds the sampled bits right-aligned, with the first bit sampled as the most significant, and zeros above.
- R7: `cfg_ss_high`=0 makes `ss` active low. `cfg_ss_high`=1 makes `ss` active high.
- R8: With `cfg_auto`=1, a burst starts as soon as the transmit FIFO holds data. With `cfg_auto`=0, no burst starts until a one-cycle `start` pulse has been seen. Until then, `ss` stays inactive.
- R9: SCLK idles low and stays low while select is inactive. Each SCLK level lasts max(`cfg_half`,1) clock cycles. MISO is sampled on the rising SCLK edge, and MOSI changes only on the falling edge.
- R10: `done` is a one-cycle pulse. It is given when a burst ends with all its bits shifted, and select is inactive in that cycle.
- R11: A word received while the receive FIFO is full is dropped. `rx_overflow` then goes high and stays high until reset.
- R12: `rx_data` and `rx_valid` hold steady while `rx_valid` is high and `rx_ready` is low. A transmit word is accepted only while `tx_ready` is high.
- R13: After reset, select is inactive, SCLK is low, `tx_ready` is high, and `rx_valid`, `done`, `underflow` and `rx_overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 12 | Burst length minus one, in bits |
| cfg_single | input | 1 | 1: select held across the whole burst; 0: select released between words |
| cfg_auto | input | 1 | 1: start when transmit data is present; 0: wait for `start` |
| cfg_ss_high | input | 1 | Select polarity; 1 means active high |
| cfg_half | input | 8 | SCLK half period in clock cycles (0 is treated as 1) |
| cfg_gap | input | 8 | Select-inactive gap, in SCLK periods |
| start | input | 1 | Start pulse used in manual mode |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit FIFO can take a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_data | output | 32 | Receive word, right-aligned |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 1 | Chip select |
| done | output | 1 | One-cycle pulse when a burst ends normally |
| underflow | output | 1 | Set when a burst ended because the transmit FIFO was empty |
| rx_overflow | output | 1 | Sticky flag for a dropped receive word |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the data:
- SCLK stays low while select is inactive.
- MOSI is steady through each high SCLK phase.
- `done` lasts one cycle, falls in a select-inactive cycle, and never coincides with `underflow`.
- The receive stream holds its data under back-pressure.
- The overflow flag is sticky.

Only the bench scenarios can show the rest. Each scenario compares the captured MOSI bit stream, the receive words and the gap lengths against a model built from the length field:
- the remainder-sized first word;
- the 4096-bit maximum burst;
- the number of select activations in each mode;
- early termination on an empty transmit FIFO;
- the manual start hold-off;
- which words survive an overflow.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 12;
  localparam int NB_W   = $clog2(WORD_W) + 1;
  localparam int REM_W  = LEN_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP
  } seq_state_e;
endpackage

// File: rtl/burst_fifo.sv
module burst_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             wr, rd;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign wr        = in_valid && in_ready;
  assign rd        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_burst_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] load_word,
  input  logic [NB_W-1:0]   load_bits,
  input  logic [DIV_W-1:0]  half_per,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              fin_o,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sr;
  logic [NB_W-1:0]   left;
  logic [DIV_W-1:0]  tick, reload;
  logic              busy;

  // Each SCLK level lasts max(half_per,1) clock cycles.
  assign reload = (half_per == '0) ? '0 : half_per - 1'b1;
  assign mosi_o = tx_sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_word <= '0;
      left    <= '0;
      tick    <= '0;
      sclk_o  <= 1'b0;
      busy    <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go) begin
        // Left-justify the word so the first bit to send sits in the MSB.
        tx_sr   <= load_word << (NB_W'(WORD_W) - load_bits);
        rx_word <= '0;
        left    <= load_bits;
        tick    <= reload;
        sclk_o  <= 1'b0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (tick != '0) begin
          tick <= tick - 1'b1;
        end else begin
          tick <= reload;
          if (!sclk_o) begin
            // Rising edge: sample MISO.
            sclk_o  <= 1'b1;
            rx_word <= {rx_word[WORD_W-2:0], miso_i};
          end else begin
            // Falling edge: advance MOSI to the next bit.
            sclk_o <= 1'b0;
            tx_sr  <= tx_sr << 1;
            left   <= left - 1'b1;
            if (left == NB_W'(1)) begin
              busy  <= 1'b0;
              fin_o <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int DIV_W    = 8,
  parameter int GAP_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_single,
  input  logic              cfg_auto,
  input  logic              cfg_ss_high,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              start,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss,
  output logic              done,
  output logic              underflow,
  output logic              rx_overflow
);
  localparam int GCNT_W = GAP_W + DIV_W + 1;

  seq_state_e        state;
  logic [REM_W-1:0]  remaining, rem_after;
  logic [NB_W-1:0]   cur_bits, first_bits, sh_bits;
  logic [GCNT_W-1:0] gap_cnt, gap_load;
  logic [DIV_W-1:0]  half_eff;
  logic              in_burst, pend, ss_act;
  logic              done_q, uf_q, ovf_q;
  logic              txf_valid, txf_pop;
  logic [WORD_W-1:0] txf_data, sh_rx;
  logic              rxf_ready, sh_go, sh_fin, begin_ok;

  burst_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .out_valid(txf_valid), .out_ready(txf_pop), .out_data(txf_data)
  );

  burst_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(sh_fin), .in_ready(rxf_ready), .in_data(sh_rx),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );

  spi_word_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go),
    .load_word(txf_data), .load_bits(sh_bits), .half_per(cfg_half),
    .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .fin_o(sh_fin), .rx_word(sh_rx)
  );

  assign half_eff   = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
  assign gap_load   = GCNT_W'(cfg_gap) * (GCNT_W'(half_eff) << 1);
  // The remainder word: low bits of the length field plus one.
  assign first_bits = NB_W'(cfg_len[NB_W-2:0]) + 1'b1;
  assign rem_after  = remaining - REM_W'(cur_bits);
  assign begin_ok   = txf_valid && (cfg_auto || pend);

  assign ss          = cfg_ss_high ? ss_act : ~ss_act;
  assign done        = done_q;
  assign underflow   = uf_q;
  assign rx_overflow = ovf_q;

  always_comb begin
    sh_go   = 1'b0;
    sh_bits = NB_W'(WORD_W);
    txf_pop = 1'b0;
    case (state)
      ST_IDLE: if (begin_ok) begin
        sh_go   = 1'b1;
        sh_bits = first_bits;
        txf_pop = 1'b1;
      end
      ST_SHIFT: if (sh_fin && rem_after != '0 && cfg_single && txf_valid) begin
        sh_go   = 1'b1;
        txf_pop = 1'b1;
      end
      ST_GAP: if (gap_cnt == '0 && in_burst && txf_valid) begin
        sh_go   = 1'b1;
        txf_pop = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      cur_bits  <= '0;
      gap_cnt   <= '0;
      in_burst  <= 1'b0;
      pend      <= 1'b0;
      ss_act    <= 1'b0;
      done_q    <= 1'b0;
      uf_q      <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_auto)   pend <= 1'b0;
      else if (start) pend <= 1'b1;
      if (sh_fin && !rxf_ready) ovf_q <= 1'b1;
      case (state)
        ST_IDLE: if (begin_ok) begin
          state     <= ST_SHIFT;
          ss_act    <= 1'b1;
          in_burst  <= 1'b1;
          remaining <= REM_W'(cfg_len) + 1'b1;
          cur_bits  <= first_bits;
          pend      <= 1'b0;
          uf_q      <= 1'b0;
        end
        ST_SHIFT: if (sh_fin) begin
          cur_bits  <= NB_W'(WORD_W);
          remaining <= rem_after;
          if (rem_after == '0) begin
            done_q   <= 1'b1;
            ss_act   <= 1'b0;
            in_burst <= 1'b0;
            gap_cnt  <= gap_load;
            state    <= ST_GAP;
          end else if (!txf_valid) begin
            uf_q     <= 1'b1;
            ss_act   <= 1'b0;
            in_burst <= 1'b0;
            gap_cnt  <= gap_load;
            state    <= ST_GAP;
          end else if (!cfg_single) begin
            ss_act  <= 1'b0;
            gap_cnt <= gap_load;
            state   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
          end else if (!in_burst) begin
            state <= ST_IDLE;
          end else if (txf_valid) begin
            ss_act <= 1'b1;
            state  <= ST_SHIFT;
          end else begin
            uf_q     <= 1'b1;
            in_burst <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_checker.sv
module spi_burst_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_ss_high,
  input logic        ss,
  input logic        sclk,
  input logic        mosi,
  input logic        done,
  input logic        underflow,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_data,
  input logic        rx_overflow
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ss != cfg_ss_high) |-> !sclk); // R9
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss != cfg_ss_high)); // R10
  AST_DONE_NOT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !underflow); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_overflow); // R11
endmodule

bind spi_burst_master spi_burst_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ss_high(cfg_ss_high), .ss(ss), .sclk(sclk),
  .mosi(mosi), .done(done), .underflow(underflow), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .rx_overflow(rx_overflow)
);

// File: tb/test_spi_burst_master.sv
module test_spi_burst_master;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [11:0] cfg_len = '0;
  logic        cfg_single = 1'b1, cfg_auto = 1'b1, cfg_ss_high = 1'b0;
  logic [7:0]  cfg_half = 8'd1, cfg_gap = 8'd0;
  logic        start = 1'b0, tx_valid = 1'b0, rx_ready = 1'b1, miso;
  logic [31:0] tx_data = '0;
  logic        tx_ready, rx_valid, sclk, mosi, ss, done, underflow, rx_overflow;
  logic [31:0] rx_data;

  spi_burst_master i_spi_burst_master (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_single(cfg_single),
    .cfg_auto(cfg_auto), .cfg_ss_high(cfg_ss_high), .cfg_half(cfg_half),
    .cfg_gap(cfg_gap), .start(start), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss(ss), .done(done),
    .underflow(underflow), .rx_overflow(rx_overflow)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(string tag, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bit pattern the SPI slave returns on MISO.
  function automatic logic slave_bit(int k);
    return ((k * 13 + 5) % 7) < 3;
  endfunction

  // Behavioural slave and line monitor.
  int  slave_k = 0, ss_events = 0, done_cnt = 0, mon_err = 0;
  int  inact_run = 0, gmin = 0, gmax = 0;
  bit  cap_q[$];
  logic [31:0] rx_q[$];
  logic sclk_d = 1'b0, act_d = 1'b0, mosi_d = 1'b0;
  logic [31:0] txw [128];
  assign miso = slave_bit(slave_k);

  always @(negedge clk) begin
    if (rst_n) begin
      logic act;
      act = (ss == cfg_ss_high);
      if (act && !act_d) begin
        if (ss_events > 0) begin
          if (inact_run < gmin) gmin = inact_run;
          if (inact_run > gmax) gmax = inact_run;
        end
        ss_events++;
        inact_run = 0;
      end
      if (!act) inact_run++;
      if (!act && sclk) mon_err++;
      if (sclk && sclk_d && mosi != mosi_d) mon_err++;
      if (act && sclk && !sclk_d) cap_q.push_back(mosi);
      if (sclk_d && !sclk) slave_k++;
      if (done) done_cnt++;
      if (rx_valid && rx_ready) rx_q.push_back(rx_data);
      sclk_d = sclk;
      act_d  = act;
      mosi_d = mosi;
    end
  end

  task automatic push_word(logic [31:0] w);
    @(posedge clk); #1;
    tx_valid = 1'b1;
    tx_data  = w;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic run(string nm, int len, int nw, bit single, bit manual, bit hold,
                     int half, int gap, logic [31:0] seed);
    int k0, tot, shifted, n0, nbits, bad, rx_exp, gexp, t;
    bit uf_exp;
    logic [31:0] v0;
    @(posedge clk); #1;
    cfg_len = 12'(len); cfg_single = single; cfg_auto = !manual;
    cfg_half = 8'(half); cfg_gap = 8'(gap); rx_ready = !hold;
    for (int i = 0; i < nw; i++) txw[i] = seed ^ (32'h01030507 * 32'(i + 1));
    @(negedge clk);
    cap_q.delete(); rx_q.delete();
    ss_events = 0; done_cnt = 0; mon_err = 0; gmin = 1 << 30; gmax = 0;
    k0 = slave_k;
    tot = len / 32 + 1;
    shifted = (nw < tot) ? nw : tot;
    uf_exp = (nw < tot);
    n0 = len % 32 + 1;
    nbits = uf_exp ? (n0 + 32 * (shifted - 1)) : (len + 1);
    for (int i = 0; i < nw; i++) push_word(txw[i]);
    if (manual) begin
      repeat (40) @(negedge clk);
      chk({nm, " R8 no start without pulse"}, ss_events == 0, ss_events, 0);
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && !underflow && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (gap * 2 * ((half == 0) ? 1 : half) + 10) @(negedge clk);
    if (hold) begin
      chk({nm, " R11 overflow flag"}, rx_overflow == (shifted > 4), rx_overflow, shifted > 4);
      v0 = rx_data;
      repeat (5) @(negedge clk);
      chk({nm, " R12 rx data held"}, rx_valid && rx_data == v0, rx_data, v0);
      @(posedge clk); #1 rx_ready = 1'b1;
      repeat (20) @(negedge clk);
    end
    // R1: MOSI bit stream
    chk({nm, " R1 bit count"}, cap_q.size() == nbits, cap_q.size(), nbits);
    bad = 0;
    for (int b = 0; b < nbits && b < cap_q.size(); b++) begin
      bit e;
      if (b < n0) e = txw[0][n0 - 1 - b];
      else e = txw[1 + (b - n0) / 32][31 - (b - n0) % 32];
      if (cap_q[b] != e) bad++;
    end
    chk({nm, " R1 bit values"}, bad == 0, bad, 0);
    // R6: receive words
    rx_exp = hold ? ((shifted < 4) ? shifted : 4) : shifted;
    chk({nm, " R6 rx count"}, rx_q.size() == rx_exp, rx_q.size(), rx_exp);
    for (int i = 0; i < rx_exp && i < rx_q.size(); i++) begin
      int ni, oi;
      logic [31:0] ev;
      ni = (i == 0) ? n0 : 32;
      oi = (i == 0) ? 0 : n0 + 32 * (i - 1);
      ev = '0;
      for (int j = 0; j < ni; j++) ev[ni - 1 - j] = slave_bit(k0 + oi + j);
      chk({nm, " R6 rx word"}, rx_q[i] == ev, rx_q[i], ev);
    end
    chk({nm, " R10 done pulses"}, done_cnt == (uf_exp ? 0 : 1), done_cnt, uf_exp ? 0 : 1);
    chk({nm, " R5 underflow flag"}, underflow == uf_exp, underflow, uf_exp);
    if (single) chk({nm, " R2 one select window"}, ss_events == 1, ss_events, 1);
    else chk({nm, " R3 select per word"}, ss_events == shifted, ss_events, shifted);
    if (!single && shifted > 1) begin
      gexp = gap * 2 * ((half == 0) ? 1 : half) + 1;
      chk({nm, " R4 gap min"}, gmin == gexp, gmin, gexp);
      chk({nm, " R4 gap max"}, gmax == gexp, gmax, gexp);
    end
    chk({nm, " R9 line discipline"}, mon_err == 0, mon_err, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=0 cycles left", WDOG);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 ss idle", ss == 1'b1, ss, 1);
    chk("R13 sclk low", sclk == 1'b0, sclk, 0);
    chk("R13 tx_ready", tx_ready == 1'b1, tx_ready, 1);
    chk("R13 flags clear", {rx_valid, done, underflow, rx_overflow} == 4'b0,
        {rx_valid, done, underflow, rx_overflow}, 0);
    run("T1 single 40b", 39, 2, 1'b1, 1'b0, 1'b0, 2, 1, 32'hA5C3_96E1);
    run("T2 per-word 64b", 63, 2, 1'b0, 1'b0, 1'b0, 1, 3, 32'h3C5A_F00F);
    run("T3 single underflow", 95, 1, 1'b1, 1'b0, 1'b0, 1, 0, 32'h1234_5678);
    @(posedge clk); #1 cfg_ss_high = 1'b1;
    @(negedge clk);
    chk("R7 active-high idle level", ss == 1'b0, ss, 0);
    run("T4 manual 1b high", 0, 1, 1'b1, 1'b1, 1'b0, 3, 0, 32'hFFFF_FFFF);
    @(posedge clk); #1 cfg_ss_high = 1'b0;
    run("T5 max 4096b", 4095, 128, 1'b1, 1'b0, 1'b0, 1, 0, 32'h0F1E_2D3C);
    run("T6 per-word underflow", 127, 2, 1'b0, 1'b0, 1'b0, 1, 2, 32'h8001_7FFE);
    run("T7 rx overflow", 191, 6, 1'b1, 1'b0, 1'b1, 1, 0, 32'hC0DE_BEEF);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule